// File: doc/BRIEF.md
# Configurable Programmable Logic Array with Output Inversion

This block is a small sum-of-products logic array. Both planes are set by configuration, so it can realise any set of functions that fit its product-term budget. A bank of AND gates forms product terms from the true or complemented form of each data input. A bank of OR gates, one per output, gathers any chosen subset of those terms. Each output then passes through an XOR stage that can invert it. With that stage, a function whose complement has a cheaper sum of products can be built from the complement's terms.

Configuration is held in registers. It is loaded one word per clock over a synchronous address/data/write-enable port: one address per product term, then one address per output. The data path from `data_in` to `data_out` is purely combinational through the stored configuration. Product terms are shared, so one term may feed several outputs. Unlike a decoder-based ROM, only the programmed terms exist.

Top module: `pla_core`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), every configuration bit is zero and every bit of `data_out` is 0 for any `data_in`.
- R2: A write to address k with k < N_TERMS programs product term k. Data bit i (0 ≤ i < N_IN) connects the true literal of input i. Data bit N_IN+i connects its complemented literal. Term k is the AND of its connected literals.
- R3: A write to address N_TERMS+j, for j < N_OUTS, programs output j. Data bit k (k < N_TERMS) connects product term k to that output's OR gate. Data bit N_TERMS is the polarity bit: when it is 1 the output is the complement of the OR result.
- R4: A product term with no literal connected evaluates to 1.
- R5: A product term with both the true and the complemented literal of the same input connected evaluates to 0.
- R6: An output with no product term connected gives 0 before the polarity stage, so it reads as its polarity bit.
- R7: One product term may feed several outputs at once, and each output sees its value.
- R8: A configuration write changes `data_out` only after the clock edge that samples the strobe. Before that edge the old configuration still applies. `data_out` follows `data_in` with no clock delay.
- R9: A write to an address at or above N_TERMS+N_OUTS changes no configuration and so leaves `data_out` unchanged.
- R10: Each output equals the XOR of its polarity bit with the OR of the selected product terms, evaluated on the current inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address (terms first, then outputs) |
| cfg_wdata | input | CFG_W | Configuration word |
| data_in | input | N_IN | Logic inputs |
| data_out | output | N_OUTS | Logic outputs after the polarity stage |

## Verification
The hardest cases to reach are the degenerate terms: a term with no literals, a term that holds a literal together with its own complement, and an output with an empty OR gate whose polarity bit alone sets its value. The bench programs each of these on purpose into spare terms and outputs, then sweeps every input combination. It also programs a pair of functions that share a term, one of them realised in inverted form, and checks both over all inputs. A long random phase follows that mixes writes to legal and unmapped addresses with input changes. A behavioural model checks every cycle, including the cycle of each write, where the old configuration must still hold.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Width of one configuration word: wide enough for a term word (2*N)
  // and for an output word (terms plus polarity bit).
  function automatic int cfg_width(input int n_in, input int n_terms);
    int tw;
    int ow;
    tw = 2 * n_in;
    ow = n_terms + 1;
    return (tw > ow) ? tw : ow;
  endfunction

  // Address width needed to reach every term and output word.
  function automatic int addr_width(input int n_terms, input int n_outs);
    int span;
    span = n_terms + n_outs;
    return (span > 1) ? $clog2(span) : 1;
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_IN    = 4,
  parameter int N_TERMS = 8,
  parameter int N_OUTS  = 4,
  parameter int ADDR_W  = 4,
  parameter int CFG_W   = 9
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [CFG_W-1:0]                  wdata,
  output logic [N_TERMS-1:0][N_IN-1:0]      lit_true,
  output logic [N_TERMS-1:0][N_IN-1:0]      lit_comp,
  output logic [N_OUTS-1:0][N_TERMS-1:0]    term_sel,
  output logic [N_OUTS-1:0]                 out_inv
);

  localparam int OUT_BASE = N_TERMS;

  // One register word per product term.
  for (genvar k = 0; k < N_TERMS; k++) begin : g_term
    logic hit;
    assign hit = we && (int'(addr) == k);
    always_ff @(posedge clk) begin
      if (rst) begin
        lit_true[k] <= '0;
        lit_comp[k] <= '0;
      end else if (hit) begin
        lit_true[k] <= wdata[N_IN-1:0];
        lit_comp[k] <= wdata[2*N_IN-1:N_IN];
      end
    end
  end

  // One register word per output: term select plus polarity.
  for (genvar j = 0; j < N_OUTS; j++) begin : g_out
    logic hit;
    assign hit = we && (int'(addr) == OUT_BASE + j);
    always_ff @(posedge clk) begin
      if (rst) begin
        term_sel[j] <= '0;
        out_inv[j]  <= 1'b0;
      end else if (hit) begin
        term_sel[j] <= wdata[N_TERMS-1:0];
        out_inv[j]  <= wdata[N_TERMS];
      end
    end
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN    = 4,
  parameter int N_TERMS = 8
) (
  input  logic [N_IN-1:0]                   x,
  input  logic [N_TERMS-1:0][N_IN-1:0]      lit_true,
  input  logic [N_TERMS-1:0][N_IN-1:0]      lit_comp,
  output logic [N_TERMS-1:0]                prod
);

  // A literal that is not connected contributes 1 to its AND gate.
  for (genvar k = 0; k < N_TERMS; k++) begin : g_prod
    logic [N_IN-1:0] pass_true;
    logic [N_IN-1:0] pass_comp;
    assign pass_true = ~lit_true[k] | x;
    assign pass_comp = ~lit_comp[k] | ~x;
    assign prod[k]   = &(pass_true & pass_comp);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERMS = 8,
  parameter int N_OUTS  = 4
) (
  input  logic [N_TERMS-1:0]                prod,
  input  logic [N_OUTS-1:0][N_TERMS-1:0]    term_sel,
  input  logic [N_OUTS-1:0]                 out_inv,
  output logic [N_OUTS-1:0]                 y
);

  for (genvar j = 0; j < N_OUTS; j++) begin : g_sum
    logic any_term;
    assign any_term = |(term_sel[j] & prod);
    assign y[j]     = any_term ^ out_inv[j];
  end

endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int N_IN    = 4,
  parameter int N_TERMS = 8,
  parameter int N_OUTS  = 4,
  parameter int ADDR_W  = pla_pkg::addr_width(N_TERMS, N_OUTS),
  parameter int CFG_W   = pla_pkg::cfg_width(N_IN, N_TERMS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [N_IN-1:0]   data_in,
  output logic [N_OUTS-1:0] data_out
);

  logic [N_TERMS-1:0][N_IN-1:0]   lit_true_w;
  logic [N_TERMS-1:0][N_IN-1:0]   lit_comp_w;
  logic [N_OUTS-1:0][N_TERMS-1:0] term_sel_w;
  logic [N_OUTS-1:0]              out_inv_w;
  logic [N_TERMS-1:0]             prod_w;

  pla_cfg_store #(
    .N_IN(N_IN), .N_TERMS(N_TERMS), .N_OUTS(N_OUTS),
    .ADDR_W(ADDR_W), .CFG_W(CFG_W)
  ) u_store (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .lit_true(lit_true_w), .lit_comp(lit_comp_w),
    .term_sel(term_sel_w), .out_inv(out_inv_w)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_and (
    .x(data_in), .lit_true(lit_true_w), .lit_comp(lit_comp_w), .prod(prod_w)
  );

  pla_or_plane #(.N_TERMS(N_TERMS), .N_OUTS(N_OUTS)) u_or (
    .prod(prod_w), .term_sel(term_sel_w), .out_inv(out_inv_w), .y(data_out)
  );

endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
  parameter int N_IN    = 4,
  parameter int N_TERMS = 8,
  parameter int N_OUTS  = 4,
  parameter int ADDR_W  = 4,
  parameter int CFG_W   = 9
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           cfg_we,
  input logic [ADDR_W-1:0]              cfg_addr,
  input logic [N_IN-1:0]                data_in,
  input logic [N_OUTS-1:0]              data_out,
  input logic [N_TERMS-1:0][N_IN-1:0]   lit_true,
  input logic [N_TERMS-1:0][N_IN-1:0]   lit_comp,
  input logic [N_OUTS-1:0][N_TERMS-1:0] term_sel,
  input logic [N_OUTS-1:0]              out_inv,
  input logic [N_TERMS-1:0]             prod
);

  localparam int LIMIT = N_TERMS + N_OUTS;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (data_out == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(data_in) -> $stable(data_out)));

  // R9
  bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (int'(cfg_addr) >= LIMIT)) |=> ($stable(data_in) -> $stable(data_out)));

  for (genvar k = 0; k < N_TERMS; k++) begin : g_tchk
    // R5
    conflict_term_chk: assert property (@(posedge clk) disable iff (rst)
      ((lit_true[k] & lit_comp[k]) != '0) |-> !prod[k]);
    // R4
    empty_term_chk: assert property (@(posedge clk) disable iff (rst)
      ((lit_true[k] | lit_comp[k]) == '0) |-> prod[k]);
  end

  for (genvar j = 0; j < N_OUTS; j++) begin : g_ochk
    // R6
    empty_out_chk: assert property (@(posedge clk) disable iff (rst)
      (term_sel[j] == '0) |-> (data_out[j] == out_inv[j]));
  end

endmodule

bind pla_core pla_core_chk #(
  .N_IN(N_IN), .N_TERMS(N_TERMS), .N_OUTS(N_OUTS), .ADDR_W(ADDR_W), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .data_in(data_in), .data_out(data_out),
  .lit_true(lit_true_w), .lit_comp(lit_comp_w),
  .term_sel(term_sel_w), .out_inv(out_inv_w), .prod(prod_w)
);

// File: tb/tb_pla_core.sv
`timescale 1ns/1ps
module tb_pla_core;
  localparam int N  = 4;
  localparam int P  = 8;
  localparam int M  = 4;
  localparam int AW = 4;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [N-1:0]  data_in = '0;
  logic [M-1:0]  data_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // Reference configuration
  bit mt [P][N];
  bit mc [P][N];
  bit ms [M][P];
  bit mp [M];

  always #2.5 clk = ~clk;

  pla_core dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .data_in(data_in), .data_out(data_out)
  );

  // Model update, mirroring the write-port contract
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < P; k++)
        for (int i = 0; i < N; i++) begin mt[k][i] = 0; mc[k][i] = 0; end
      for (int j = 0; j < M; j++) begin
        mp[j] = 0;
        for (int k = 0; k < P; k++) ms[j][k] = 0;
      end
    end else if (cfg_we) begin
      int a;
      a = int'(cfg_addr);
      if (a < P) begin
        for (int i = 0; i < N; i++) begin
          mt[a][i] = cfg_wdata[i];
          mc[a][i] = cfg_wdata[N+i];
        end
      end else if (a < P + M) begin
        for (int k = 0; k < P; k++) ms[a-P][k] = cfg_wdata[k];
        mp[a-P] = cfg_wdata[P];
      end
    end
  end

  function automatic logic [M-1:0] expected(input logic [N-1:0] x);
    bit term [P];
    logic [M-1:0] r;
    for (int k = 0; k < P; k++) begin
      term[k] = 1;
      for (int i = 0; i < N; i++) begin
        if (mt[k][i] && !x[i]) term[k] = 0;
        if (mc[k][i] && x[i])  term[k] = 0;
      end
    end
    for (int j = 0; j < M; j++) begin
      bit s;
      s = 0;
      for (int k = 0; k < P; k++) if (ms[j][k] && term[k]) s = 1;
      r[j] = s ^ mp[j];
    end
    return r;
  endfunction

  task automatic step(input bit we, input int addr, input int wd, input int x);
    logic [M-1:0] e;
    @(negedge clk);
    cfg_we    = we;
    cfg_addr  = AW'(addr);
    cfg_wdata = CW'(wd);
    data_in   = N'(x);
    #1;
    e = expected(data_in);
    checks++;
    if (data_out !== e) begin
      errors++;
      $display("FAIL %s: in=%b actual=%b expected=%b", tag, data_in, data_out, e);
    end
  endtask

  task automatic sweep();
    for (int v = 0; v < (1 << N); v++) step(0, 0, 0, v);
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (2) step(0, 0, 0, 5);
    rst = 1'b0;
    sweep();

    // R2 R3 R10 R7: F1 = AB' + AC + A'BC', F2 = (AC + BC)', with A=bit2, B=bit1, C=bit0
    tag = "R2";
    step(1, 0, 'h024, 0);          // AB'
    step(1, 1, 'h005, 0);          // AC
    step(1, 2, 'h052, 0);          // A'BC'
    step(1, 3, 'h003, 0);          // BC
    tag = "R3";
    step(1, 8, 'h007, 0);
    step(1, 9, 'h10A, 0);          // inverted output sharing AC
    tag = "R10";
    sweep();
    tag = "R7";
    sweep();

    // R4: empty term on output 2
    tag = "R4";
    step(1, 4, 'h000, 3);
    step(1, 10, 'h010, 3);
    sweep();

    // R5: term with A and A' on output 3, plain then inverted
    tag = "R5";
    step(1, 5, 'h044, 4);
    step(1, 11, 'h020, 4);
    sweep();
    step(1, 11, 'h120, 4);
    sweep();

    // R6: empty OR gate, polarity alone
    tag = "R6";
    step(1, 10, 'h100, 6);
    sweep();
    step(1, 10, 'h000, 6);
    sweep();

    // R8: write and check old/new value around the edge
    tag = "R8";
    step(1, 10, 'h010, 9);
    step(0, 0, 0, 9);
    step(1, 10, 'h000, 9);
    step(0, 0, 0, 9);

    // R9: unmapped addresses
    tag = "R9";
    for (int a = P + M; a < (1 << AW); a++) begin
      step(1, a, 'h1FF, 7);
      step(0, 0, 0, 7);
      sweep();
    end

    // R10: random mix
    tag = "R10";
    for (int n = 0; n < 600; n++)
      step(($urandom % 3) == 0, $urandom % (1 << AW), $urandom % (1 << CW), $urandom % (1 << N));

    // R1 again: reset after programming
    tag = "R1";
    @(negedge clk); rst = 1'b1;
    step(0, 0, 0, 2);
    rst = 1'b0;
    sweep();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule